// File: doc/BRIEF.md
# Multi-cycle integer multiply/divide unit

This block computes the eight integer multiply, high-multiply, divide and remainder operations of a 32-bit processor. It sits next to a single-cycle ALU. The datapath issues an operation with a one-cycle `start` pulse, a 3-bit operation code and two operands. It then holds its own progress while `busy` is high, and takes the value on `result` in the cycle when `done` pulses.

Multiplies pass through three registered stages: operand capture, product, and half select. Divides and remainders use a restoring shift-subtract loop that produces one quotient bit per cycle. The loop works on operand magnitudes, and the signs are corrected in a final step. A zero divisor and signed overflow produce fixed results and raise no exception. The two paths have different latencies, and both latencies are fixed.

Top module: `mdu_unit`

## Requirements
- R1: `op` selects the operation: 000 low product, 001 signed×signed high product, 010 signed `src_a` × unsigned `src_b` high product, 011 unsigned×unsigned high product, 100 signed quotient, 101 unsigned quotient, 110 signed remainder, 111 unsigned remainder.
- R2: Code 000 returns the low 32 bits of the product. For every code below 100, `done` is high in the third cycle after the cycle in which `start` was accepted.
- R3: Codes 001, 010 and 011 return bits 63..32 of the 64-bit product, with each operand treated as signed or unsigned as listed in R1.
- R4: Quotients truncate toward zero, and a signed remainder takes the sign of the dividend. For every code of 100 or above, `done` is high in the 34th cycle after the accepting cycle.
- R5: With `src_b` zero, the quotient codes return all ones and the remainder codes return `src_a` unchanged.
- R6: Signed division of 0x80000000 by 0xFFFFFFFF returns 0x80000000 as the quotient and 0 as the remainder.
- R7: `busy` is high in every cycle from the one after an accepted start up to the cycle before `done`, and is low while `done` is high. A start in the `done` cycle is accepted.
- R8: A `start` that arrives while `busy` is high is ignored. The running operation finishes with its own result and its own latency.
- R9: `done` is high for exactly one cycle. `result` keeps its value from the `done` cycle until the next accepted start.
- R10: While `rst` is high, `busy`, `done` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, taken only while idle |
| op | input | 3 | Operation code (R1) |
| src_a | input | XLEN | First operand (multiplicand or dividend) |
| src_b | input | XLEN | Second operand (multiplier or divisor) |
| busy | output | 1 | An operation is in flight |
| done | output | 1 | One-cycle completion pulse |
| result | output | XLEN | Result of the last completed operation |

## Verification
The assertions take for granted that reset is held for at least one clock edge before any start. They also assume `start` is a clean, synchronous level: every 3-bit code is legal, and starts may arrive at any time, including while busy. The stimulus applies reset first and changes inputs only on the falling clock edge. It covers starts that land mid-divide and starts issued in the `done` cycle, so the ignore and back-to-back paths are exercised without breaking those assumptions.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    typedef enum logic [2:0] {
        OP_MUL    = 3'b000,
        OP_MULH   = 3'b001,
        OP_MULHSU = 3'b010,
        OP_MULHU  = 3'b011,
        OP_DIV    = 3'b100,
        OP_DIVU   = 3'b101,
        OP_REM    = 3'b110,
        OP_REMU   = 3'b111
    } mdu_op_e;

    // Codes with the top bit set use the iterative divider.
    function automatic logic op_is_div(mdu_op_e op);
        return op[2];
    endfunction

    function automatic logic op_a_signed(mdu_op_e op);
        return (op == OP_MULH) || (op == OP_MULHSU) || (op == OP_DIV) || (op == OP_REM);
    endfunction

    function automatic logic op_b_signed(mdu_op_e op);
        return (op == OP_MULH) || (op == OP_DIV) || (op == OP_REM);
    endfunction

    function automatic logic op_wants_high(mdu_op_e op);
        return op != OP_MUL;
    endfunction

    function automatic logic op_wants_rem(mdu_op_e op);
        return op[1];
    endfunction

    typedef struct packed {
        logic neg_quo;
        logic neg_rem;
        logic want_rem;
        logic by_zero;
    } div_ctl_t;

endpackage

// File: rtl/mdu_mul.sv
module mdu_mul
    import mdu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  mdu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            busy,
    output logic            valid,
    output logic [XLEN-1:0] result
);
    localparam int EW = XLEN + 1;
    localparam int PW = 2 * EW;

    logic signed [EW-1:0] s1_a, s1_b;
    logic                 s1_hi, s1_v;
    logic signed [PW-1:0] s2_prod;
    logic                 s2_hi, s2_v;
    logic [XLEN-1:0]      res_q;
    logic                 v_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_a    <= '0;
            s1_b    <= '0;
            s1_hi   <= 1'b0;
            s1_v    <= 1'b0;
            s2_prod <= '0;
            s2_hi   <= 1'b0;
            s2_v    <= 1'b0;
            res_q   <= '0;
            v_q     <= 1'b0;
        end else begin
            s1_v <= go;
            if (go) begin
                s1_a  <= {op_a_signed(op) & a[XLEN-1], a};
                s1_b  <= {op_b_signed(op) & b[XLEN-1], b};
                s1_hi <= op_wants_high(op);
            end
            s2_v <= s1_v;
            if (s1_v) begin
                s2_prod <= s1_a * s1_b;
                s2_hi   <= s1_hi;
            end
            v_q <= s2_v;
            if (s2_v) begin
                res_q <= s2_hi ? s2_prod[2*XLEN-1:XLEN] : s2_prod[XLEN-1:0];
            end
        end
    end

    assign busy   = s1_v | s2_v;
    assign valid  = v_q;
    assign result = res_q;

    // R2: every stage hands its operation on, one stage per cycle.
    a_r2_stage_chain: assert property (@(posedge clk) disable iff (rst)
        s1_v |=> (s2_v && !s1_v) || (s2_v && $past(go)));
    a_r2_last_stage: assert property (@(posedge clk) disable iff (rst)
        s2_v |=> v_q);
    // R3: the extended product always fits in 2*XLEN+1 bits.
    a_r3_product_fits: assert property (@(posedge clk) disable iff (rst)
        v_q |-> (s2_prod[PW-1] == s2_prod[PW-2]));

endmodule

// File: rtl/mdu_div.sv
module mdu_div
    import mdu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  mdu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            busy,
    output logic            valid,
    output logic [XLEN-1:0] result
);
    localparam int CW = $clog2(XLEN + 1);

    logic            run, fin, v_q;
    logic [CW-1:0]   cnt;
    logic [XLEN-1:0] quo, rem, dvs, dend, res_q;
    div_ctl_t        ctl;

    logic            a_neg, b_neg;
    logic [XLEN:0]   shifted;
    logic [XLEN+1:0] diff;
    logic            borrow;
    logic [XLEN-1:0] q_fix, r_fix;

    always_comb begin
        a_neg   = op_a_signed(op) & a[XLEN-1];
        b_neg   = op_b_signed(op) & b[XLEN-1];
        shifted = {rem, quo[XLEN-1]};
        diff    = {1'b0, shifted} - {2'b00, dvs};
        borrow  = diff[XLEN+1];
        q_fix   = ctl.neg_quo ? (~quo + 1'b1) : quo;
        r_fix   = ctl.neg_rem ? (~rem + 1'b1) : rem;
        if (ctl.by_zero) begin
            q_fix = '1;
            r_fix = dend;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            fin   <= 1'b0;
            v_q   <= 1'b0;
            cnt   <= '0;
            quo   <= '0;
            rem   <= '0;
            dvs   <= '0;
            dend  <= '0;
            res_q <= '0;
            ctl   <= '0;
        end else begin
            v_q <= 1'b0;
            if (go) begin
                run          <= 1'b1;
                cnt          <= CW'(XLEN);
                quo          <= a_neg ? (~a + 1'b1) : a;
                dvs          <= b_neg ? (~b + 1'b1) : b;
                rem          <= '0;
                dend         <= a;
                ctl.neg_quo  <= a_neg ^ b_neg;
                ctl.neg_rem  <= a_neg;
                ctl.want_rem <= op_wants_rem(op);
                ctl.by_zero  <= (b == '0);
            end else if (run) begin
                quo <= {quo[XLEN-2:0], ~borrow};
                rem <= borrow ? shifted[XLEN-1:0] : diff[XLEN-1:0];
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end else if (fin) begin
                fin   <= 1'b0;
                v_q   <= 1'b1;
                res_q <= ctl.want_rem ? r_fix : q_fix;
            end
        end
    end

    assign busy   = run | fin;
    assign valid  = v_q;
    assign result = res_q;

    // R4: the loop counts down by one each step, then hands over to the fix-up.
    a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
        (run && cnt != CW'(1)) |=> (run && cnt == $past(cnt) - 1'b1));
    a_r4_to_fixup: assert property (@(posedge clk) disable iff (rst)
        (run && cnt == CW'(1)) |=> (fin && !run));
    // R4: a partial remainder that is kept always fits in XLEN bits.
    a_r4_rem_fits: assert property (@(posedge clk) disable iff (rst)
        (run && !borrow) |-> !diff[XLEN]);
    // R5: a zero divisor yields an all-ones quotient.
    a_r5_zero_quotient: assert property (@(posedge clk) disable iff (rst)
        (fin && ctl.by_zero && !ctl.want_rem) |=> (res_q == '1));

endmodule

// File: rtl/mdu_unit.sv
module mdu_unit
    import mdu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [2:0]      op,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] result
);
    mdu_op_e         op_e;
    logic            launch, go_mul, go_div;
    logic            mul_busy, mul_valid, div_busy, div_valid;
    logic [XLEN-1:0] mul_res, div_res;
    logic            sel_div;

    always_comb begin
        op_e   = mdu_op_e'(op);
        launch = start & ~busy;
        go_mul = launch & ~op_is_div(op_e);
        go_div = launch & op_is_div(op_e);
    end

    mdu_mul #(.XLEN(XLEN)) i_mul (
        .clk(clk), .rst(rst), .go(go_mul), .op(op_e), .a(src_a), .b(src_b),
        .busy(mul_busy), .valid(mul_valid), .result(mul_res)
    );

    mdu_div #(.XLEN(XLEN)) i_div (
        .clk(clk), .rst(rst), .go(go_div), .op(op_e), .a(src_a), .b(src_b),
        .busy(div_busy), .valid(div_valid), .result(div_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_div <= 1'b0;
        end else if (launch) begin
            sel_div <= op_is_div(op_e);
        end
    end

    assign busy   = mul_busy | div_busy;
    assign done   = mul_valid | div_valid;
    assign result = sel_div ? div_res : mul_res;

    // R7: busy and done never overlap; an accepted start raises busy.
    a_r7_busy_not_done: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));
    a_r7_busy_after_launch: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    // R8: a start during busy does not cut the operation short.
    a_r8_no_abort: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> (busy || done));
    // R9: done is a single-cycle pulse and result holds while idle.
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(result));

endmodule

// File: tb/test_mdu_unit.sv
module test_mdu_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op = 3'b000;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        busy, done;
    logic [31:0] result;

    int n_chk  = 0;
    int n_fail = 0;

    localparam int MUL_LAT = 3;
    localparam int DIV_LAT = 34;

    always #4 clk = ~clk;

    mdu_unit #(.XLEN(32)) i_mdu_unit (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .src_a(src_a), .src_b(src_b),
        .busy(busy), .done(done), .result(result)
    );

    task automatic check(input bit cond, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [2:0] f, input logic [31:0] a,
                                          input logic [31:0] b);
        longint          sa, sb, sp;
        longint unsigned ua, ub, up;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        ua = {32'h0, a};
        ub = {32'h0, b};
        case (f)
            3'b000: begin up = ua * ub; return up[31:0]; end
            3'b001: begin sp = sa * sb; return sp[63:32]; end
            3'b010: begin sp = sa * longint'(ub); return sp[63:32]; end
            3'b011: begin up = ua * ub; return up[63:32]; end
            3'b100: begin
                if (b == 0) return 32'hFFFF_FFFF;
                if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return a;
                sp = sa / sb; return sp[31:0];
            end
            3'b101: begin
                if (b == 0) return 32'hFFFF_FFFF;
                return a / b;
            end
            3'b110: begin
                if (b == 0) return a;
                if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h0;
                sp = sa % sb; return sp[31:0];
            end
            default: begin
                if (b == 0) return a;
                return a % b;
            end
        endcase
    endfunction

    // Called at a falling edge; returns one falling edge later (cycle 1).
    task automatic launch(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b);
        start = 1'b1; op = f; src_a = a; src_b = b;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Counts from cycle 1; returns at the falling edge where done is high.
    task automatic wait_done(input int lat, input logic [31:0] exp, input string req);
        int  k = 1;
        bit  busy_ok = 1'b1;
        while (!done && k <= lat + 4) begin
            busy_ok &= busy;
            @(negedge clk);
            k++;
        end
        check(done && k == lat, req, "latency", 64'(k), 64'(lat));
        check(busy_ok, "R7", "busy while running", 64'(busy_ok), 64'd1);
        check(!busy, "R7", "busy low at done", 64'(busy), 64'd0);
        check(result === exp, req, "result", 64'(result), 64'(exp));
    endtask

    task automatic run_op(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b,
                          input string req);
        launch(f, a, b);
        wait_done(f[2] ? DIV_LAT : MUL_LAT, model(f, a, b), req);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(busy === 1'b0, "R10", "busy in reset", 64'(busy), 64'd0);
        check(done === 1'b0, "R10", "done in reset", 64'(done), 64'd0);
        check(result === 32'h0, "R10", "result in reset", 64'(result), 64'd0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_multiply;
        run_op(3'b000, 32'd1234, 32'd5678, "R2");
        run_op(3'b000, 32'hFFFF_FFFF, 32'h0000_0003, "R2");
        run_op(3'b001, 32'hFFFF_FFFE, 32'h0000_0007, "R3");
        run_op(3'b001, 32'h8000_0000, 32'h8000_0000, "R3");
        run_op(3'b010, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
        run_op(3'b010, 32'h7FFF_0000, 32'h9000_0001, "R3");
        run_op(3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
        run_op(3'b011, 32'h1234_5678, 32'h9ABC_DEF0, "R1");
    endtask

    task automatic t_divide;
        run_op(3'b100, 32'd100, 32'd7, "R4");
        run_op(3'b100, 32'hFFFF_FF9C, 32'd7, "R4");
        run_op(3'b100, 32'd100, 32'hFFFF_FFF9, "R4");
        run_op(3'b101, 32'hFFFF_FF9C, 32'd7, "R4");
        run_op(3'b110, 32'hFFFF_FF9C, 32'd7, "R4");
        run_op(3'b110, 32'd100, 32'hFFFF_FFF9, "R4");
        run_op(3'b111, 32'hDEAD_BEEF, 32'h0001_0000, "R4");
        run_op(3'b101, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1");
    endtask

    task automatic t_div_zero;
        run_op(3'b100, 32'hFFFF_FF9C, 32'h0, "R5");
        run_op(3'b101, 32'd55, 32'h0, "R5");
        run_op(3'b110, 32'hFFFF_FF9C, 32'h0, "R5");
        run_op(3'b111, 32'hCAFE_0001, 32'h0, "R5");
    endtask

    task automatic t_overflow;
        run_op(3'b100, 32'h8000_0000, 32'hFFFF_FFFF, "R6");
        run_op(3'b110, 32'h8000_0000, 32'hFFFF_FFFF, "R6");
        run_op(3'b101, 32'h8000_0000, 32'hFFFF_FFFF, "R6");
    endtask

    task automatic t_ignore_start;
        launch(3'b100, 32'd1000, 32'd7);
        repeat (3) @(negedge clk);
        start = 1'b1; op = 3'b000; src_a = 32'd5; src_b = 32'd5;
        @(negedge clk);
        start = 1'b0; src_a = 32'd9; src_b = 32'd0;
        // cycle 5 now; the mid-run start must not shorten or change the divide
        wait_done_from(5, DIV_LAT, 32'd142, "R8");
    endtask

    task automatic wait_done_from(input int k0, input int lat, input logic [31:0] exp,
                                  input string req);
        int k = k0;
        bit early = 1'b0;
        while (!done && k <= lat + 4) begin
            @(negedge clk);
            k++;
        end
        early = (k != lat);
        check(!early && done, req, "latency with ignored start", 64'(k), 64'(lat));
        check(result === exp, req, "result with ignored start", 64'(result), 64'(exp));
    endtask

    task automatic t_hold;
        logic [31:0] kept;
        run_op(3'b011, 32'hF000_0000, 32'h0000_0010, "R9");
        kept = result;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(!done, "R9", "done single cycle", 64'(done), 64'd0);
            check(result === kept, "R9", "result held", 64'(result), 64'(kept));
        end
    endtask

    task automatic t_back_to_back;
        run_op(3'b110, 32'd77, 32'd10, "R7");
        // start issued in the done cycle must be taken
        run_op(3'b000, 32'd300, 32'd300, "R7");
        run_op(3'b101, 32'd300, 32'd299, "R7");
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_multiply();
        t_divide();
        t_div_zero();
        t_overflow();
        t_ignore_start();
        t_hold();
        t_back_to_back();
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule